// File: doc/BRIEF.md
# Dispatch Stage with Skid Buffer

This block sits between the rename stage and the out-of-order back end of one hardware thread. Each cycle it accepts up to `W` renamed instructions. It routes them in program order to an issue queue, a load queue and a store queue, and it stops at the first instruction that cannot be placed. Each instruction carries a tag and six flags: load, store, atomic, nop, squashed and non-speculative. The downstream queues report only whether they are full.

When dispatch cannot continue, the stage moves the instructions it could not place into a small skid buffer and signals rename to hold off. While the stall lasts, any late arrivals are appended behind them. Once the stall clears, the stage first drains the skid buffer and then takes new instructions from rename again, so program order is never broken. A squash request from commit empties the buffer and discards all traffic until the request drops.

The stage reports how many instructions, loads and stores it retired from its input each cycle. Rename uses these counts to track free queue space. It also exposes its control state and a sticky flag that records any overrun of the skid buffer.

Top module: `dispatch_stage`

## Requirements
- R1: Dispatch is in program order and takes at most `W` instructions per cycle. The dispatched lanes are always lanes 0 to n-1 of `dispValid`. A plain instruction goes to the issue queue. A load goes to the issue and load queues. A store or an atomic goes to the issue and store queues. A non-speculative instruction that enters the issue queue also raises `dispNonSpec` on its lane.
- R2: In Running, a high `commitStall` or a high `iqFull` stops all dispatch in that cycle. The stage moves every valid incoming instruction into the skid buffer and enters Blocked. No issue-queue write happens in any cycle where `iqFull` is high.
- R3: With `lqFull` high, dispatch stops at the first load. With `sqFull` high, dispatch stops at the first store or atomic. The instructions ahead of it are dispatched. That instruction and everything behind it go to the skid buffer, and the stage enters Blocked.
- R4: An instruction flagged squashed is consumed and counted in `dispCount`. It writes no queue and never causes a stall, even when its own queue is full.
- R5: A nop that is not squashed raises `dispNopDone`. It takes no issue-, load- or store-queue entry, and its memory flags are ignored.
- R6: Blocked moves to Unblocking only when neither `commitStall` nor `iqFull` is high and the oldest buffered instruction can be placed. In Unblocking, instructions come only from the skid buffer, and new arrivals are appended behind the buffered ones. The stage returns to Running in the cycle after the buffer becomes empty.
- R7: A high `squashIn` empties the skid buffer, discards all incoming instructions and puts the stage in Squashing. No dispatch happens in Squashing. The stage returns to Running in the cycle after `squashIn` is seen low.
- R8: An attempt to hold more than `DEPTH` instructions in the skid buffer sets `skidOverrun`. The flag stays set until reset.
- R9: `dispCount` is the number of instructions consumed in the cycle. `dispLqCount` counts those with the load flag. `dispSqCount` counts those with the store or atomic flag. Squashed instructions are included in both counts, and nops are excluded from both.
- R10: `blockPulse` is high for exactly one cycle after each entry into Blocked. `unblockPulse` is high for exactly one cycle after each move from Unblocking to Running, and after each move from Blocked or Unblocking into Squashing.
- R11: `stageState` encodes Running=0, Blocked=1, Unblocking=2 and Squashing=3. Reset, which is asynchronous and active low, gives Running with no dispatch, both pulses low and `skidOverrun` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| squashIn | input | 1 | Squash request from commit |
| commitStall | input | 1 | Commit is squashing; stall dispatch |
| iqFull | input | 1 | Issue queue has no room |
| lqFull | input | 1 | Load queue has no room |
| sqFull | input | 1 | Store queue has no room |
| inCount | input | $clog2(W+1) | Number of valid rename lanes, packed from lane 0 |
| inTag | input | W x TAG_W | Per-lane instruction tag |
| inLoad | input | W | Per-lane load flag |
| inStore | input | W | Per-lane store flag |
| inAtomic | input | W | Per-lane atomic flag |
| inNop | input | W | Per-lane nop flag |
| inSquashed | input | W | Per-lane already-squashed flag |
| inNonSpec | input | W | Per-lane non-speculative flag |
| dispValid | output | W | Lane consumed this cycle |
| dispToIq | output | W | Lane written to the issue queue |
| dispToLq | output | W | Lane written to the load queue |
| dispToSq | output | W | Lane written to the store queue |
| dispNopDone | output | W | Lane is a nop marked executed and ready to commit |
| dispNonSpec | output | W | Issue-queue write is non-speculative |
| dispTag | output | W x TAG_W | Tag of each dispatched lane |
| dispCount | output | $clog2(W+1) | Instructions consumed this cycle |
| dispLqCount | output | $clog2(W+1) | Loads consumed this cycle |
| dispSqCount | output | $clog2(W+1) | Stores and atomics consumed this cycle |
| blockPulse | output | 1 | One-cycle notice to rename: stage blocked |
| unblockPulse | output | 1 | One-cycle notice to rename: stage unblocked |
| stageState | output | 2 | Current control state |
| skidOverrun | output | 1 | Sticky skid buffer overrun flag |

## Verification
Some properties are checked on every cycle. No issue-, load- or store-queue write may happen while that queue reports full. The skid buffer must be empty whenever the stage is Running or Squashing. Neither notice pulse may last two cycles. The overrun flag must never clear without a reset. Other behaviour can only be shown by the directed scenarios. These include the program order across the skid buffer, the exact lane where a full load or store queue cuts off dispatch, and a blocked head that holds the stage in Blocked. They also include the count reporting for squashed and nop instructions and the cycle-exact state sequence through each stall and squash.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  // per-instruction attribute flags carried with each lane
  typedef struct packed {
    logic load;
    logic store;
    logic atomic;
    logic nop;
    logic squashed;
    logic nonSpec;
  } instFlags_t;

  // control states, encoding visible on stageState
  typedef enum logic [1:0] {
    ST_RUN        = 2'd0,
    ST_BLOCKED    = 2'd1,
    ST_UNBLOCKING = 2'd2,
    ST_SQUASHING  = 2'd3
  } dispState_t;

  // strobes from the control to the datapath skid storage
  typedef struct packed {
    logic pushEn;    // append incoming lanes to the skid buffer
    logic pushRest;  // append only lanes from dispN onward
    logic flush;     // discard all buffered entries
  } skidCtl_t;

endpackage

// File: rtl/dsp_datapath.sv
module dsp_datapath
  import dsp_pkg::*;
#(
  parameter int W     = 4,
  parameter int TAG_W = 8,
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      useSkid,
  input  skidCtl_t                  ctl,
  input  logic [$clog2(W+1)-1:0]    dispN,
  input  logic [$clog2(W+1)-1:0]    inCount,
  input  logic [W-1:0][TAG_W-1:0]   inTag,
  input  instFlags_t                inFlags [W],
  output logic [$clog2(W+1)-1:0]    candCount,
  output logic [W-1:0]              candNeedIq,
  output logic [W-1:0]              candNeedLq,
  output logic [W-1:0]              candNeedSq,
  output logic [$clog2(DEPTH+1)-1:0] skidCount,
  output logic                      skidOverrun,
  output logic [W-1:0]              dispValid,
  output logic [W-1:0]              dispToIq,
  output logic [W-1:0]              dispToLq,
  output logic [W-1:0]              dispToSq,
  output logic [W-1:0]              dispNopDone,
  output logic [W-1:0]              dispNonSpec,
  output logic [W-1:0][TAG_W-1:0]   dispTag,
  output logic [$clog2(W+1)-1:0]    dispCount,
  output logic [$clog2(W+1)-1:0]    dispLqCount,
  output logic [$clog2(W+1)-1:0]    dispSqCount
);

  localparam int CW = $clog2(W + 1);
  localparam int SW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = (W > 1) ? $clog2(W) : 1;

  function automatic int wrapIdx(input int base, input int off);
    int s;
    s = base + off;
    if (s >= DEPTH) s = s - DEPTH;
    return s;
  endfunction

  // skid storage
  instFlags_t         memFlags [DEPTH];
  logic [TAG_W-1:0]   memTag   [DEPTH];
  logic [PW-1:0]      rdPtr, wrPtr;
  logic [SW-1:0]      count;

  // candidate window seen by the control
  instFlags_t         candFlags [W];
  logic [TAG_W-1:0]   candTag   [W];

  int popN, pushFrom, pushN, afterPop, room, keepN;
  logic overNow;

  always_comb begin
    int avail;
    avail = (int'(count) > W) ? W : int'(count);
    candCount = useSkid ? CW'(avail) : inCount;
    for (int i = 0; i < W; i++) begin
      if (useSkid) begin
        candFlags[i] = memFlags[PW'(wrapIdx(int'(rdPtr), i))];
        candTag[i]   = memTag[PW'(wrapIdx(int'(rdPtr), i))];
      end else begin
        candFlags[i] = inFlags[i];
        candTag[i]   = inTag[i];
      end
      candNeedIq[i] = !candFlags[i].squashed && !candFlags[i].nop;
      candNeedLq[i] = candNeedIq[i] && candFlags[i].load;
      candNeedSq[i] = candNeedIq[i] && (candFlags[i].store || candFlags[i].atomic);
    end
  end

  // push / pop arithmetic
  always_comb begin
    popN     = useSkid ? int'(dispN) : 0;
    pushFrom = ctl.pushRest ? int'(dispN) : 0;
    pushN    = ctl.pushEn ? (int'(inCount) - pushFrom) : 0;
    afterPop = int'(count) - popN;
    room     = DEPTH - afterPop;
    overNow  = pushN > room;
    keepN    = overNow ? room : pushN;
  end

  // lane routing toward the queues
  always_comb begin
    int nLd, nSt;
    nLd = 0;
    nSt = 0;
    for (int i = 0; i < W; i++) begin
      dispValid[i]   = i < int'(dispN);
      dispToIq[i]    = dispValid[i] && candNeedIq[i];
      dispToLq[i]    = dispValid[i] && candNeedLq[i];
      dispToSq[i]    = dispValid[i] && candNeedSq[i];
      dispNopDone[i] = dispValid[i] && !candFlags[i].squashed && candFlags[i].nop;
      dispNonSpec[i] = dispToIq[i] && candFlags[i].nonSpec;
      dispTag[i]     = dispValid[i] ? candTag[i] : '0;
      if (dispValid[i] && !candFlags[i].nop && candFlags[i].load) nLd++;
      if (dispValid[i] && !candFlags[i].nop &&
          (candFlags[i].store || candFlags[i].atomic)) nSt++;
    end
    dispCount   = dispN;
    dispLqCount = CW'(nLd);
    dispSqCount = CW'(nSt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr       <= '0;
      wrPtr       <= '0;
      count       <= '0;
      skidOverrun <= 1'b0;
    end else if (ctl.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      rdPtr <= PW'(wrapIdx(int'(rdPtr), popN));
      wrPtr <= PW'(wrapIdx(int'(wrPtr), keepN));
      count <= SW'(afterPop + keepN);
      if (overNow) skidOverrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < W; j++) begin
      if (!ctl.flush && j < keepN) begin
        memFlags[PW'(wrapIdx(int'(wrPtr), j))] <= inFlags[LW'(pushFrom + j)];
        memTag[PW'(wrapIdx(int'(wrPtr), j))]   <= inTag[LW'(pushFrom + j)];
      end
    end
  end

  assign skidCount = count;

  // R8: the overrun flag never clears without reset
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    skidOverrun |=> skidOverrun);

endmodule

// File: rtl/dsp_ctrl.sv
module dsp_ctrl
  import dsp_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       squashIn,
  input  logic                       commitStall,
  input  logic                       iqFull,
  input  logic                       lqFull,
  input  logic                       sqFull,
  input  logic [$clog2(W+1)-1:0]     inCount,
  input  logic [$clog2(W+1)-1:0]     candCount,
  input  logic [W-1:0]               candNeedIq,
  input  logic [W-1:0]               candNeedLq,
  input  logic [W-1:0]               candNeedSq,
  input  logic [$clog2(DEPTH+1)-1:0] skidCount,
  output logic                       useSkid,
  output skidCtl_t                   ctl,
  output logic [$clog2(W+1)-1:0]     dispN,
  output dispState_t                 state,
  output logic                       blockPulse,
  output logic                       unblockPulse
);

  localparam int CW = $clog2(W + 1);

  dispState_t nxt;
  int         nOk;
  logic       headBlk, stallNow, doBlock, doUnblock;

  // how many leading candidates can be placed this cycle
  always_comb begin
    logic stopped;
    stopped = 1'b0;
    nOk     = 0;
    for (int i = 0; i < W; i++) begin
      if (i < int'(candCount) && !stopped) begin
        if ((candNeedIq[i] && iqFull) || (candNeedLq[i] && lqFull) ||
            (candNeedSq[i] && sqFull))
          stopped = 1'b1;
        else
          nOk = i + 1;
      end
    end
    headBlk  = (candCount != '0) && (nOk == 0);
    stallNow = commitStall || iqFull;
  end

  assign useSkid = (state == ST_BLOCKED) || (state == ST_UNBLOCKING);

  always_comb begin
    nxt       = state;
    dispN     = '0;
    ctl       = '0;
    doBlock   = 1'b0;
    doUnblock = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (squashIn) begin
          nxt       = ST_SQUASHING;
          ctl.flush = 1'b1;
        end else if (stallNow) begin
          ctl.pushEn = 1'b1;
          nxt        = ST_BLOCKED;
          doBlock    = 1'b1;
        end else begin
          dispN = CW'(nOk);
          if (nOk < int'(candCount)) begin
            ctl.pushEn   = 1'b1;
            ctl.pushRest = 1'b1;
            nxt          = ST_BLOCKED;
            doBlock      = 1'b1;
          end
        end
      end
      ST_BLOCKED: begin
        if (squashIn) begin
          nxt       = ST_SQUASHING;
          ctl.flush = 1'b1;
          doUnblock = 1'b1;
        end else begin
          ctl.pushEn = 1'b1;
          if (!stallNow && !headBlk) nxt = ST_UNBLOCKING;
        end
      end
      ST_UNBLOCKING: begin
        if (squashIn) begin
          nxt       = ST_SQUASHING;
          ctl.flush = 1'b1;
          doUnblock = 1'b1;
        end else if (stallNow) begin
          ctl.pushEn = 1'b1;
          nxt        = ST_BLOCKED;
          doBlock    = 1'b1;
        end else begin
          dispN      = CW'(nOk);
          ctl.pushEn = 1'b1;
          if (nOk < int'(candCount)) begin
            nxt     = ST_BLOCKED;
            doBlock = 1'b1;
          end else if (int'(skidCount) - nOk + int'(inCount) == 0) begin
            nxt       = ST_RUN;
            doUnblock = 1'b1;
          end
        end
      end
      default: begin
        ctl.flush = 1'b1;
        if (!squashIn) nxt = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_RUN;
      blockPulse   <= 1'b0;
      unblockPulse <= 1'b0;
    end else begin
      state        <= nxt;
      blockPulse   <= doBlock;
      unblockPulse <= doUnblock;
    end
  end

  // R10: each notice to rename lasts a single cycle
  p_block_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    blockPulse |=> !blockPulse);
  p_unblock_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    unblockPulse |=> !unblockPulse);
  // R10: a block notice always accompanies the Blocked state
  p_block_state_r10: assert property (@(posedge clk) disable iff (!rstN)
    blockPulse |-> state == ST_BLOCKED);

endmodule

// File: rtl/dispatch_stage.sv
module dispatch_stage
  import dsp_pkg::*;
#(
  parameter int W     = 4,
  parameter int TAG_W = 8,
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      squashIn,
  input  logic                      commitStall,
  input  logic                      iqFull,
  input  logic                      lqFull,
  input  logic                      sqFull,
  input  logic [$clog2(W+1)-1:0]    inCount,
  input  logic [W-1:0][TAG_W-1:0]   inTag,
  input  logic [W-1:0]              inLoad,
  input  logic [W-1:0]              inStore,
  input  logic [W-1:0]              inAtomic,
  input  logic [W-1:0]              inNop,
  input  logic [W-1:0]              inSquashed,
  input  logic [W-1:0]              inNonSpec,
  output logic [W-1:0]              dispValid,
  output logic [W-1:0]              dispToIq,
  output logic [W-1:0]              dispToLq,
  output logic [W-1:0]              dispToSq,
  output logic [W-1:0]              dispNopDone,
  output logic [W-1:0]              dispNonSpec,
  output logic [W-1:0][TAG_W-1:0]   dispTag,
  output logic [$clog2(W+1)-1:0]    dispCount,
  output logic [$clog2(W+1)-1:0]    dispLqCount,
  output logic [$clog2(W+1)-1:0]    dispSqCount,
  output logic                      blockPulse,
  output logic                      unblockPulse,
  output logic [1:0]                stageState,
  output logic                      skidOverrun
);

  localparam int CW = $clog2(W + 1);
  localparam int SW = $clog2(DEPTH + 1);

  instFlags_t        inFlags [W];
  logic              useSkid;
  skidCtl_t          ctl;
  logic [CW-1:0]     dispN, candCount;
  logic [W-1:0]      candNeedIq, candNeedLq, candNeedSq;
  logic [SW-1:0]     skidCount;
  dispState_t        state;

  for (genvar g = 0; g < W; g++) begin : g_lane
    assign inFlags[g] = '{load: inLoad[g], store: inStore[g], atomic: inAtomic[g],
                          nop: inNop[g], squashed: inSquashed[g],
                          nonSpec: inNonSpec[g]};
  end

  dsp_ctrl #(.W(W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .squashIn(squashIn), .commitStall(commitStall),
    .iqFull(iqFull), .lqFull(lqFull), .sqFull(sqFull), .inCount(inCount),
    .candCount(candCount), .candNeedIq(candNeedIq), .candNeedLq(candNeedLq),
    .candNeedSq(candNeedSq), .skidCount(skidCount), .useSkid(useSkid),
    .ctl(ctl), .dispN(dispN), .state(state), .blockPulse(blockPulse),
    .unblockPulse(unblockPulse)
  );

  dsp_datapath #(.W(W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .useSkid(useSkid), .ctl(ctl), .dispN(dispN),
    .inCount(inCount), .inTag(inTag), .inFlags(inFlags),
    .candCount(candCount), .candNeedIq(candNeedIq), .candNeedLq(candNeedLq),
    .candNeedSq(candNeedSq), .skidCount(skidCount), .skidOverrun(skidOverrun),
    .dispValid(dispValid), .dispToIq(dispToIq), .dispToLq(dispToLq),
    .dispToSq(dispToSq), .dispNopDone(dispNopDone), .dispNonSpec(dispNonSpec),
    .dispTag(dispTag), .dispCount(dispCount), .dispLqCount(dispLqCount),
    .dispSqCount(dispSqCount)
  );

  assign stageState = state;

  // R2: nothing enters a full issue queue
  p_iq_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    iqFull |-> dispToIq == '0);
  // R3: nothing enters a full load or store queue
  p_lq_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    lqFull |-> dispToLq == '0);
  p_sq_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    sqFull |-> dispToSq == '0);
  // R6: new arrivals bypass the buffer only when it is empty
  p_run_skid_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RUN |-> skidCount == '0);
  // R7: squashing leaves nothing buffered and dispatches nothing
  p_squash_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SQUASHING |-> (skidCount == '0 && dispValid == '0));

endmodule

// File: tb/test_dispatch_stage.sv
`timescale 1ns/1ps
module test_dispatch_stage;

  localparam int W     = 4;
  localparam int TAG_W = 8;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(W + 1);

  logic clk = 1'b0;
  logic rstN;
  logic squashIn, commitStall, iqFull, lqFull, sqFull;
  logic [CW-1:0] inCount;
  logic [W-1:0][TAG_W-1:0] inTag;
  logic [W-1:0] inLoad, inStore, inAtomic, inNop, inSquashed, inNonSpec;
  logic [W-1:0] dispValid, dispToIq, dispToLq, dispToSq, dispNopDone, dispNonSpec;
  logic [W-1:0][TAG_W-1:0] dispTag;
  logic [CW-1:0] dispCount, dispLqCount, dispSqCount;
  logic blockPulse, unblockPulse, skidOverrun;
  logic [1:0] stageState;

  int nChecks = 0;
  int nBad    = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dispatch_stage #(.W(W), .TAG_W(TAG_W), .DEPTH(DEPTH)) i_dispatch_stage (
    .clk(clk), .rstN(rstN), .squashIn(squashIn), .commitStall(commitStall),
    .iqFull(iqFull), .lqFull(lqFull), .sqFull(sqFull), .inCount(inCount),
    .inTag(inTag), .inLoad(inLoad), .inStore(inStore), .inAtomic(inAtomic),
    .inNop(inNop), .inSquashed(inSquashed), .inNonSpec(inNonSpec),
    .dispValid(dispValid), .dispToIq(dispToIq), .dispToLq(dispToLq),
    .dispToSq(dispToSq), .dispNopDone(dispNopDone), .dispNonSpec(dispNonSpec),
    .dispTag(dispTag), .dispCount(dispCount), .dispLqCount(dispLqCount),
    .dispSqCount(dispSqCount), .blockPulse(blockPulse),
    .unblockPulse(unblockPulse), .stageState(stageState),
    .skidOverrun(skidOverrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clearIn();
    inCount = '0; inTag = '0; inLoad = '0; inStore = '0; inAtomic = '0;
    inNop = '0; inSquashed = '0; inNonSpec = '0;
  endtask

  task automatic putLane(input int i, input int tag, input bit ld, input bit st,
                         input bit at, input bit np, input bit sq, input bit ns);
    inTag[i] = tag[TAG_W-1:0];
    inLoad[i] = ld; inStore[i] = st; inAtomic[i] = at;
    inNop[i] = np; inSquashed[i] = sq; inNonSpec[i] = ns;
  endtask

  task automatic testReset();
    rstN = 1'b0; squashIn = 0; commitStall = 0; iqFull = 0; lqFull = 0; sqFull = 0;
    clearIn();
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset state", stageState, 0);
    chk("R11", "reset dispValid", dispValid, 0);
    chk("R11", "reset blockPulse", blockPulse, 0);
    chk("R11", "reset unblockPulse", unblockPulse, 0);
    chk("R11", "reset overrun", skidOverrun, 0);
    rstN = 1'b1;
    tick();
  endtask

  task automatic testRouting();
    putLane(0, 1, 0, 0, 0, 0, 0, 0);
    putLane(1, 2, 1, 0, 0, 0, 0, 0);
    putLane(2, 3, 0, 1, 0, 0, 0, 0);
    putLane(3, 4, 0, 0, 1, 0, 0, 1);
    inCount = 4;
    #1;
    chk("R1", "valid", dispValid, 4'b1111);
    chk("R1", "toIq", dispToIq, 4'b1111);
    chk("R1", "toLq", dispToLq, 4'b0010);
    chk("R1", "toSq", dispToSq, 4'b1100);
    chk("R1", "nonSpec", dispNonSpec, 4'b1000);
    chk("R1", "tag lane1", dispTag[1], 2);
    chk("R9", "count", dispCount, 4);
    chk("R9", "lq count", dispLqCount, 1);
    chk("R9", "sq count", dispSqCount, 2);
    tick();
    chk("R1", "state stays running", stageState, 0);
    clearIn();
  endtask

  task automatic testNopSquashed();
    lqFull = 1;
    putLane(0, 5, 0, 0, 0, 1, 0, 0);
    putLane(1, 6, 1, 0, 0, 0, 1, 0);
    putLane(2, 7, 0, 0, 0, 0, 0, 0);
    inCount = 3;
    #1;
    chk("R4", "valid incl squashed", dispValid, 4'b0111);
    chk("R5", "nop done", dispNopDone, 4'b0001);
    chk("R5", "nop and squashed skip IQ", dispToIq, 4'b0100);
    chk("R4", "squashed load not in LQ", dispToLq, 0);
    chk("R9", "count incl squashed", dispCount, 3);
    chk("R9", "lq count incl squashed", dispLqCount, 1);
    tick();
    chk("R4", "no stall from squashed", stageState, 0);
    lqFull = 0;
    clearIn();
  endtask

  task automatic testLqStop();
    lqFull = 1;
    putLane(0, 10, 0, 0, 0, 0, 0, 0);
    putLane(1, 11, 0, 0, 0, 0, 0, 0);
    putLane(2, 12, 1, 0, 0, 0, 0, 0);
    putLane(3, 13, 0, 0, 0, 0, 0, 0);
    inCount = 4;
    #1;
    chk("R3", "stop before load", dispValid, 4'b0011);
    chk("R3", "tag lane0", dispTag[0], 10);
    tick();
    chk("R3", "blocked", stageState, 1);
    chk("R10", "block pulse", blockPulse, 1);
    clearIn();
    #1;
    chk("R6", "no dispatch while blocked", dispValid, 0);
    tick();
    chk("R6", "head load holds blocked", stageState, 1);
    chk("R10", "block pulse single", blockPulse, 0);
    lqFull = 0;
    tick();
    chk("R6", "unblocking", stageState, 2);
    putLane(0, 14, 0, 0, 0, 0, 0, 0);
    inCount = 1;
    #1;
    chk("R6", "drain valid", dispValid, 4'b0011);
    chk("R6", "drain oldest first", dispTag[0], 12);
    chk("R6", "drain second", dispTag[1], 13);
    chk("R1", "drained load to LQ", dispToLq, 4'b0001);
    tick();
    chk("R6", "still unblocking", stageState, 2);
    clearIn();
    #1;
    chk("R6", "late arrival after buffer", dispTag[0], 14);
    chk("R6", "late arrival valid", dispValid, 4'b0001);
    tick();
    chk("R6", "back to running", stageState, 0);
    chk("R10", "unblock pulse", unblockPulse, 1);
    tick();
    chk("R10", "unblock pulse single", unblockPulse, 0);
  endtask

  task automatic testIqStall();
    iqFull = 1;
    putLane(0, 20, 0, 0, 0, 0, 0, 0);
    putLane(1, 21, 0, 0, 0, 0, 0, 0);
    inCount = 2;
    #1;
    chk("R2", "no dispatch iq full", dispValid, 0);
    tick();
    chk("R2", "blocked by iq", stageState, 1);
    chk("R10", "block pulse iq", blockPulse, 1);
    iqFull = 0;
    clearIn();
    tick();
    chk("R6", "unblocking after iq", stageState, 2);
    #1;
    chk("R2", "buffered pair", dispValid, 4'b0011);
    chk("R2", "buffered tag1", dispTag[1], 21);
    tick();
    chk("R6", "running after iq", stageState, 0);
  endtask

  task automatic testCommitStall();
    commitStall = 1;
    putLane(0, 30, 0, 0, 0, 0, 0, 0);
    inCount = 1;
    #1;
    chk("R2", "no dispatch commit stall", dispValid, 0);
    tick();
    chk("R2", "blocked by commit", stageState, 1);
    commitStall = 0;
    clearIn();
    tick();
    #1;
    chk("R2", "commit stall replay tag", dispTag[0], 30);
    tick();
    chk("R6", "running after commit", stageState, 0);
  endtask

  task automatic testSqHead();
    sqFull = 1;
    putLane(0, 50, 0, 1, 0, 0, 0, 0);
    putLane(1, 51, 0, 0, 0, 0, 0, 0);
    inCount = 2;
    #1;
    chk("R3", "store first blocks all", dispValid, 0);
    tick();
    chk("R3", "blocked by sq", stageState, 1);
    clearIn();
    tick();
    chk("R6", "store head holds blocked", stageState, 1);
    sqFull = 0;
    tick();
    chk("R6", "unblocking after sq", stageState, 2);
    #1;
    chk("R3", "store to SQ", dispToSq, 4'b0001);
    chk("R3", "store tag", dispTag[0], 50);
    tick();
    chk("R6", "running after sq", stageState, 0);
  endtask

  task automatic testSquash();
    iqFull = 1;
    for (int i = 0; i < 4; i++) putLane(i, 40 + i, 0, 0, 0, 0, 0, 0);
    inCount = 4;
    tick();
    chk("R2", "blocked before squash", stageState, 1);
    squashIn = 1;
    clearIn();
    putLane(0, 44, 0, 0, 0, 0, 0, 0);
    inCount = 1;
    #1;
    chk("R7", "no dispatch on squash", dispValid, 0);
    tick();
    chk("R7", "squashing", stageState, 3);
    chk("R10", "unblock on squash", unblockPulse, 1);
    putLane(0, 45, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R7", "no dispatch while squashing", dispValid, 0);
    tick();
    chk("R7", "still squashing", stageState, 3);
    chk("R10", "unblock single", unblockPulse, 0);
    squashIn = 0;
    iqFull = 0;
    clearIn();
    tick();
    chk("R7", "running after squash", stageState, 0);
    putLane(0, 46, 0, 0, 0, 0, 0, 0);
    inCount = 1;
    #1;
    chk("R7", "old entries gone", dispTag[0], 46);
    chk("R7", "fresh dispatch", dispValid, 4'b0001);
    tick();
    clearIn();
  endtask

  task automatic testOverrun();
    iqFull = 1;
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 4; i++) putLane(i, 60 + 4 * k + i, 0, 0, 0, 0, 0, 0);
      inCount = 4;
      tick();
      if (k == 1) chk("R8", "full buffer no overrun", skidOverrun, 0);
    end
    chk("R8", "overrun set", skidOverrun, 1);
    clearIn();
    tick();
    chk("R8", "overrun sticky", skidOverrun, 1);
    rstN = 0;
    iqFull = 0;
    #1;
    chk("R11", "reset clears overrun", skidOverrun, 0);
    chk("R11", "reset state running", stageState, 0);
    tick();
    rstN = 1;
    tick();
  endtask

  initial begin
    testReset();
    testRouting();
    testNopSquashed();
    testLqStop();
    testIqStall();
    testCommitStall();
    testSqHead();
    testSquash();
    testOverrun();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule